// File: doc/BRIEF.md
# I2C Role and Address Controller

This block is the control core of a two-wire serial bus interface that can work as a slave or as a master, and can transmit or receive in either role. It keeps track of the present role and data direction. When software asks for a START or a STOP, it passes the request to a bit-level engine. It also decides whether an address byte seen on the bus selects this node while the node is a slave.

Software drives one-cycle command strobes for START and STOP, together with a read/write level. The bit engine reports bus events as one-cycle flags: START seen, STOP seen, arbitration lost, and address/data byte received with its value. A programmable digital filter delay is applied to every bus event before the block uses it. The block reports the current mode and gives a one-cycle match pulse that carries the kind of address matched. It also sends one-cycle START and STOP requests to the bit engine.

The node becomes master as soon as it requests a START. It goes back to slave when it loses arbitration, when it requests a STOP, or when a STOP appears on the bus. Because of this, several masters can share one bus.

Top module: `i2c_role_ctrl`

## Requirements
- R1: `mode_o` encodes four operating modes: bit 1 is set in master mode, and bit 0 is set when the node transmits. The codes are 00 slave receiver, 01 slave transmitter, 10 master receiver and 11 master transmitter.
- R2: After reset `mode_o` is 00 (slave receiver), and `match_o`, `match_kind_o`, `req_start_o` and `req_stop_o` are all 0.
- R3: A `cmd_start_i` strobe in cycle n gives `req_start_o` = 1 for exactly cycle n+1, with `mode_o` in master from cycle n+1. The direction comes from `cmd_read_i`: 1 gives master receiver and 0 gives master transmitter. A strobe while already master is a repeated START that reloads the direction.
- R4: An arbitration-loss event while master sets `mode_o` to 00 one cycle after the filtered event. The event has no effect while slave.
- R5: A `cmd_stop_i` strobe while master gives `req_stop_o` = 1 for one cycle and `mode_o` = 00 in the next cycle. A stop strobe while slave has no effect. A request output is never raised without its command, and the two requests are never high together.
- R6: In 7-bit mode (`cfg_addr10_i` = 0), the first byte after a START matches when its bits [7:1] equal `cfg_own_addr_i[6:0]`. `match_o` pulses one cycle after the filtered byte event with `match_kind_o` = 01. Byte bit 0 sets the slave direction: 1 gives slave transmitter and 0 gives slave receiver.
- R7: In 10-bit mode, a first byte of 11110, `cfg_own_addr_i[9:8]`, 0 followed by a second byte equal to `cfg_own_addr_i[7:0]` matches as own (kind 01, slave receiver). No pulse appears after the header alone. After such a match and before a STOP, a repeated-START header with bit 0 = 1 matches as own with slave transmitter. In 10-bit mode a 7-bit compare never matches.
- R8: The first byte 0x00 matches as general call (kind 10, slave receiver) only when `cfg_gcall_en_i` = 1.
- R9: When `cfg_smb_en_i` = 1, first bytes whose bits [7:1] are 0x08, 0x0C or 0x61 match with kind 11, and the direction comes from bit 0. They do not match when the bit is 0. An own-address match takes priority over this kind.
- R10: No address match occurs while master. After an arbitration loss, the address byte of the same transfer is matched as a slave.
- R11: Every bus event is delayed by `cfg_dnf_i` clock cycles (0 to 15) before it affects state.
- R12: Only the first byte after a START, or the second byte of a 10-bit header, is compared; later data bytes never match. A STOP seen ends the address phase, returns a slave to receiver, and forgets an earlier 10-bit match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Software START command strobe |
| cmd_stop_i | input | 1 | Software STOP command strobe |
| cmd_read_i | input | 1 | Master direction for the START: 1 read, 0 write |
| ev_start_i | input | 1 | Bit engine: START seen on the bus |
| ev_stop_i | input | 1 | Bit engine: STOP seen on the bus |
| ev_arb_lost_i | input | 1 | Bit engine: arbitration lost |
| ev_byte_i | input | 1 | Bit engine: byte received, value on `byte_i` |
| byte_i | input | 8 | Received byte value |
| cfg_own_addr_i | input | 10 | Own slave address |
| cfg_addr10_i | input | 1 | 1 selects 10-bit own address |
| cfg_gcall_en_i | input | 1 | General call recognition enable |
| cfg_smb_en_i | input | 1 | Reserved SMBus address recognition enable |
| cfg_dnf_i | input | 4 | Event filter delay in clock cycles |
| mode_o | output | 2 | Mode: bit 1 master, bit 0 transmitter |
| match_o | output | 1 | One-cycle address match pulse |
| match_kind_o | output | 2 | Match kind: 01 own, 10 general call, 11 SMBus reserved, 00 none |
| req_start_o | output | 1 | START request to the bit engine |
| req_stop_o | output | 1 | STOP request to the bit engine |

## Verification
The matcher is tried with equal and unequal 7-bit addresses in both read and write, and with 10-bit header-then-second-byte pairs, both correct and corrupted. Repeated-START read headers are sent both before and after a STOP, which shows whether the 10-bit memory is kept and cleared at the right points. General call and SMBus reserved bytes are sent with their enables on and off, and an own address that overlaps a reserved one tests the priority. Role tests put a START command, arbitration loss and STOP command in master and in slave state, so that effective and ignored stimuli are told apart. An address byte received as master is compared with the same byte received after arbitration loss. A nonzero filter delay is checked to move the match pulse by exactly that many cycles.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;

    typedef enum logic [1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'b00,
        HIT_OWN   = 2'b01,
        HIT_GCALL = 2'b10,
        HIT_SMB   = 2'b11
    } hit_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'b00,
        PH_FIRST  = 2'b01,
        PH_SECOND = 2'b10
    } phase_e;

    // one bundle of bit-engine events as seen in one clock cycle
    typedef struct packed {
        logic       start_seen;
        logic       stop_seen;
        logic       arb_lost;
        logic       byte_rdy;
        logic [7:0] data;
    } bus_ev_t;

    localparam logic [4:0] TEN_HDR_TAG  = 5'b11110;
    localparam logic [6:0] SMB_HOST     = 7'h08;
    localparam logic [6:0] SMB_ALERT    = 7'h0C;
    localparam logic [6:0] SMB_DEFAULT  = 7'h61;

endpackage

// File: rtl/i2c_ev_delay.sv
module i2c_ev_delay
    import i2c_role_pkg::*;
#(
    parameter int DNF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DNF_W-1:0] dnf_i,
    input  bus_ev_t          ev_i,
    output bus_ev_t          ev_o
);
    localparam int DEPTH = (1 << DNF_W) - 1;

    typedef struct packed {
        bus_ev_t [DEPTH-1:0] pipe;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = ev_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // tap 0 is the undelayed event; tap k is k registers deep
    always_comb begin
        if (dnf_i == '0) ev_o = ev_i;
        else             ev_o = st_q.pipe[dnf_i - 1'b1];
    end

endmodule

// File: rtl/i2c_role_fsm.sv
module i2c_role_fsm
    import i2c_role_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start_i,
    input  logic cmd_stop_i,
    input  logic cmd_read_i,
    input  logic start_seen_i,
    input  logic stop_seen_i,
    input  logic arb_lost_i,
    input  logic hit_i,
    input  logic hit_rd_i,
    output logic slave_o,
    output logic [1:0] mode_o,
    output logic req_start_o,
    output logic req_stop_o
);
    typedef struct packed {
        logic master;
        logic tx;
        logic req_start;
        logic req_stop;
    } role_st_t;

    role_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.req_start = 1'b0;
        st_d.req_stop  = 1'b0;
        if (st_q.master) begin
            if (arb_lost_i) begin
                st_d.master = 1'b0;
                st_d.tx     = 1'b0;
            end else if (cmd_stop_i) begin
                st_d.master   = 1'b0;
                st_d.tx       = 1'b0;
                st_d.req_stop = 1'b1;
            end else if (cmd_start_i) begin
                st_d.tx        = !cmd_read_i;
                st_d.req_start = 1'b1;
            end else if (stop_seen_i) begin
                st_d.master = 1'b0;
                st_d.tx     = 1'b0;
            end
        end else begin
            if (cmd_start_i) begin
                st_d.master    = 1'b1;
                st_d.tx        = !cmd_read_i;
                st_d.req_start = 1'b1;
            end else if (hit_i) begin
                st_d.tx = hit_rd_i;
            end else if (stop_seen_i || start_seen_i) begin
                st_d.tx = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slave_o     = !st_q.master;
    assign mode_o      = {st_q.master, st_q.tx};
    assign req_start_o = st_q.req_start;
    assign req_stop_o  = st_q.req_stop;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_role_pkg::*;
#(
    parameter int OWN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_i,
    input  logic             start_seen_i,
    input  logic             stop_seen_i,
    input  logic             byte_rdy_i,
    input  logic [7:0]       data_i,
    input  logic [OWN_W-1:0] own_i,
    input  logic             ten_i,
    input  logic             gcall_en_i,
    input  logic             smb_en_i,
    output logic             hit_o,
    output logic             hit_rd_o,
    output logic             match_o,
    output logic [1:0]       kind_o
);
    localparam int A7_W = 7;

    typedef struct packed {
        phase_e phase;
        logic   ten_ok;
        logic   match;
        hit_e   kind;
    } am_st_t;

    am_st_t     st_d, st_q;
    hit_e       cand;
    logic       cand_rd;
    logic [6:0] a7;
    logic       hdr_ok;
    logic       smb_addr;

    assign a7       = data_i[7:1];
    assign hdr_ok   = (data_i[7:3] == TEN_HDR_TAG) && (data_i[2:1] == own_i[OWN_W-1 -: 2]);
    assign smb_addr = (a7 == SMB_HOST) || (a7 == SMB_ALERT) || (a7 == SMB_DEFAULT);

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        st_d.kind  = HIT_NONE;
        cand       = HIT_NONE;
        cand_rd    = 1'b0;
        if (stop_seen_i) begin
            st_d.phase  = PH_OFF;
            st_d.ten_ok = 1'b0;
        end else if (start_seen_i) begin
            st_d.phase = PH_FIRST;
        end else if (byte_rdy_i) begin
            case (st_q.phase)
                PH_FIRST: begin
                    st_d.phase = PH_OFF;
                    cand_rd    = data_i[0];
                    if (!(ten_i && hdr_ok && data_i[0])) st_d.ten_ok = 1'b0;
                    if (ten_i && hdr_ok) begin
                        if (!data_i[0])       st_d.phase = PH_SECOND;
                        else if (st_q.ten_ok) cand = HIT_OWN;
                    end else if (!ten_i && (a7 == own_i[A7_W-1:0])) begin
                        cand = HIT_OWN;
                    end else if (gcall_en_i && (data_i == 8'h00)) begin
                        cand = HIT_GCALL;
                    end else if (smb_en_i && smb_addr) begin
                        cand = HIT_SMB;
                    end
                end
                PH_SECOND: begin
                    st_d.phase = PH_OFF;
                    cand_rd    = 1'b0;
                    if (data_i == own_i[7:0]) begin
                        cand = HIT_OWN;
                        if (slave_i) st_d.ten_ok = 1'b1;
                    end
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
        hit_o    = slave_i && (cand != HIT_NONE);
        hit_rd_o = cand_rd;
        if (hit_o) begin
            st_d.match = 1'b1;
            st_d.kind  = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o = st_q.match;
    assign kind_o  = st_q.kind;

endmodule

// File: rtl/i2c_role_ctrl.sv
module i2c_role_ctrl
    import i2c_role_pkg::*;
#(
    parameter int DNF_W = 4,
    parameter int OWN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start_i,
    input  logic             cmd_stop_i,
    input  logic             cmd_read_i,
    input  logic             ev_start_i,
    input  logic             ev_stop_i,
    input  logic             ev_arb_lost_i,
    input  logic             ev_byte_i,
    input  logic [7:0]       byte_i,
    input  logic [OWN_W-1:0] cfg_own_addr_i,
    input  logic             cfg_addr10_i,
    input  logic             cfg_gcall_en_i,
    input  logic             cfg_smb_en_i,
    input  logic [DNF_W-1:0] cfg_dnf_i,
    output logic [1:0]       mode_o,
    output logic             match_o,
    output logic [1:0]       match_kind_o,
    output logic             req_start_o,
    output logic             req_stop_o
);
    bus_ev_t ev_raw, ev_f;
    logic    slave, hit, hit_rd;

    assign ev_raw = '{start_seen: ev_start_i, stop_seen: ev_stop_i,
                      arb_lost: ev_arb_lost_i, byte_rdy: ev_byte_i, data: byte_i};

    i2c_ev_delay #(.DNF_W(DNF_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .dnf_i (cfg_dnf_i),
        .ev_i  (ev_raw),
        .ev_o  (ev_f)
    );

    i2c_role_fsm u_role (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start_i  (cmd_start_i),
        .cmd_stop_i   (cmd_stop_i),
        .cmd_read_i   (cmd_read_i),
        .start_seen_i (ev_f.start_seen),
        .stop_seen_i  (ev_f.stop_seen),
        .arb_lost_i   (ev_f.arb_lost),
        .hit_i        (hit),
        .hit_rd_i     (hit_rd),
        .slave_o      (slave),
        .mode_o       (mode_o),
        .req_start_o  (req_start_o),
        .req_stop_o   (req_stop_o)
    );

    i2c_addr_match #(.OWN_W(OWN_W)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .slave_i      (slave),
        .start_seen_i (ev_f.start_seen),
        .stop_seen_i  (ev_f.stop_seen),
        .byte_rdy_i   (ev_f.byte_rdy),
        .data_i       (ev_f.data),
        .own_i        (cfg_own_addr_i),
        .ten_i        (cfg_addr10_i),
        .gcall_en_i   (cfg_gcall_en_i),
        .smb_en_i     (cfg_smb_en_i),
        .hit_o        (hit),
        .hit_rd_o     (hit_rd),
        .match_o      (match_o),
        .kind_o       (match_kind_o)
    );

endmodule

// File: rtl/i2c_role_ctrl_chk.sv
module i2c_role_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start_i,
    input logic       cmd_stop_i,
    input logic       arb_f,
    input logic [1:0] mode_o,
    input logic       match_o,
    input logic [1:0] match_kind_o,
    input logic       req_start_o,
    input logic       req_stop_o
);
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_i && !(mode_o[1] && (arb_f || cmd_stop_i))) |=> (req_start_o && mode_o[1]));

    assert_arb_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1] && arb_f) |=> (mode_o == 2'b00));

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1] && cmd_stop_i && !arb_f) |=> (req_stop_o && mode_o == 2'b00));

    assert_no_stray_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stop_i |=> !req_stop_o);

    assert_no_stray_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_start_i |=> !req_start_o);

    assert_req_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_start_o, req_stop_o}));

    assert_kind_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (match_kind_o != 2'b00));

    assert_kind_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (match_kind_o == 2'b00));

    assert_slave_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> !$past(mode_o[1]));

endmodule

bind i2c_role_ctrl i2c_role_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start_i  (cmd_start_i),
    .cmd_stop_i   (cmd_stop_i),
    .arb_f        (ev_f.arb_lost),
    .mode_o       (mode_o),
    .match_o      (match_o),
    .match_kind_o (match_kind_o),
    .req_start_o  (req_start_o),
    .req_stop_o   (req_stop_o)
);

// File: tb/sim_i2c_role_ctrl.sv
module sim_i2c_role_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0, cmd_stop = 1'b0, cmd_read = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, ev_arb = 1'b0, ev_byte = 1'b0;
    logic [7:0] byte_v = 8'h00;
    logic [9:0] own = 10'h02A;
    logic       addr10 = 1'b0, gc_en = 1'b0, smb_en = 1'b0;
    logic [3:0] dnf = 4'd0;
    logic [1:0] mode;
    logic       match;
    logic [1:0] kind;
    logic       req_start, req_stop;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    i2c_role_ctrl u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start_i    (cmd_start),
        .cmd_stop_i     (cmd_stop),
        .cmd_read_i     (cmd_read),
        .ev_start_i     (ev_start),
        .ev_stop_i      (ev_stop),
        .ev_arb_lost_i  (ev_arb),
        .ev_byte_i      (ev_byte),
        .byte_i         (byte_v),
        .cfg_own_addr_i (own),
        .cfg_addr10_i   (addr10),
        .cfg_gcall_en_i (gc_en),
        .cfg_smb_en_i   (smb_en),
        .cfg_dnf_i      (dnf),
        .mode_o         (mode),
        .match_o        (match),
        .match_kind_o   (kind),
        .req_start_o    (req_start),
        .req_stop_o     (req_stop)
    );

    task automatic expect_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // every driver starts and ends at a falling edge
    task automatic do_start(bit rd);
        cmd_read = rd; cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
    endtask
    task automatic do_stop();
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    endtask
    task automatic bus_start();
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask
    task automatic bus_stop();
        ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask
    task automatic bus_arb();
        ev_arb = 1'b1; @(negedge clk); ev_arb = 1'b0;
    endtask
    task automatic bus_byte(logic [7:0] b);
        byte_v = b; ev_byte = 1'b1; @(negedge clk); ev_byte = 1'b0;
    endtask

    task automatic t_reset();
        expect_eq("R2 mode after reset", mode, 0);
        expect_eq("R2 match after reset", match, 0);
        expect_eq("R2 kind after reset", kind, 0);
        expect_eq("R2 req_start after reset", req_start, 0);
        expect_eq("R2 req_stop after reset", req_stop, 0);
    endtask

    task automatic t_master();
        do_start(1'b0);
        expect_eq("R3 req_start pulse", req_start, 1);
        expect_eq("R1 R3 master transmitter", mode, 3);
        @(negedge clk);
        expect_eq("R3 req_start one cycle", req_start, 0);
        do_start(1'b1);
        expect_eq("R3 repeated start req", req_start, 1);
        expect_eq("R1 R3 master receiver", mode, 2);
        do_stop();
        expect_eq("R5 req_stop pulse", req_stop, 1);
        expect_eq("R5 back to slave", mode, 0);
        @(negedge clk);
        do_stop();
        expect_eq("R5 stop ignored in slave", req_stop, 0);
        expect_eq("R5 mode kept in slave", mode, 0);
    endtask

    task automatic t_master_no_match();
        do_start(1'b0);
        bus_start();
        bus_byte({own[6:0], 1'b0});
        expect_eq("R10 no match as master", match, 0);
        expect_eq("R10 still master", mode, 3);
        do_stop();
        @(negedge clk);
    endtask

    task automatic t_arb();
        do_start(1'b0);
        bus_start();
        bus_arb();
        expect_eq("R4 arbitration loss to slave", mode, 0);
        bus_byte({own[6:0], 1'b1});
        expect_eq("R10 match after arbitration loss", match, 1);
        expect_eq("R10 kind own", kind, 1);
        expect_eq("R10 R6 slave transmitter", mode, 1);
        bus_stop();
        expect_eq("R12 stop returns slave receiver", mode, 0);
        bus_arb();
        expect_eq("R4 arbitration loss ignored in slave", mode, 0);
    endtask

    task automatic t_seven();
        bus_start();
        bus_byte({own[6:0], 1'b0});
        expect_eq("R6 own write match", match, 1);
        expect_eq("R6 own kind", kind, 1);
        expect_eq("R6 slave receiver", mode, 0);
        @(negedge clk);
        expect_eq("R6 match one cycle", match, 0);
        bus_byte({own[6:0], 1'b1});
        expect_eq("R12 data byte not matched", match, 0);
        expect_eq("R12 data byte no direction change", mode, 0);
        bus_start();
        bus_byte({own[6:0] ^ 7'h01, 1'b0});
        expect_eq("R6 other address no match", match, 0);
        bus_start();
        bus_byte({own[6:0], 1'b1});
        expect_eq("R6 own read match", match, 1);
        expect_eq("R6 slave transmitter", mode, 1);
        bus_stop();
        expect_eq("R12 stop clears transmitter", mode, 0);
    endtask

    task automatic t_gcall();
        gc_en = 1'b0;
        bus_start();
        bus_byte(8'h00);
        expect_eq("R8 general call disabled", match, 0);
        gc_en = 1'b1;
        bus_start();
        bus_byte(8'h00);
        expect_eq("R8 general call match", match, 1);
        expect_eq("R8 general call kind", kind, 2);
        bus_stop();
        gc_en = 1'b0;
    endtask

    task automatic t_smb();
        smb_en = 1'b0;
        bus_start();
        bus_byte(8'h10);
        expect_eq("R9 reserved disabled", match, 0);
        smb_en = 1'b1;
        bus_start();
        bus_byte(8'h10);
        expect_eq("R9 host address kind", kind, 3);
        bus_start();
        bus_byte(8'h19);
        expect_eq("R9 alert address match", match, 1);
        expect_eq("R9 alert read direction", mode, 1);
        bus_start();
        bus_byte(8'hC2);
        expect_eq("R9 default address kind", kind, 3);
        own = 10'h008;
        bus_start();
        bus_byte(8'h10);
        expect_eq("R9 own has priority", kind, 1);
        bus_stop();
        own = 10'h02A;
        smb_en = 1'b0;
    endtask

    task automatic t_ten();
        addr10 = 1'b1;
        own = 10'h2A5;
        bus_start();
        bus_byte(8'hF4);
        expect_eq("R7 no pulse after header", match, 0);
        bus_byte(8'hA5);
        expect_eq("R7 ten-bit match", match, 1);
        expect_eq("R7 ten-bit kind", kind, 1);
        expect_eq("R7 ten-bit slave receiver", mode, 0);
        bus_start();
        bus_byte(8'hF5);
        expect_eq("R7 repeated start read header", match, 1);
        expect_eq("R7 slave transmitter", mode, 1);
        bus_stop();
        bus_start();
        bus_byte(8'hF5);
        expect_eq("R12 stop forgets ten-bit match", match, 0);
        bus_start();
        bus_byte(8'hF4);
        bus_byte(8'hA4);
        expect_eq("R7 wrong second byte", match, 0);
        bus_start();
        bus_byte({7'h25, 1'b0});
        expect_eq("R7 seven-bit compare off", match, 0);
        bus_stop();
        addr10 = 1'b0;
        own = 10'h02A;
    endtask

    task automatic t_filter();
        dnf = 4'd3;
        bus_start();
        bus_byte({own[6:0], 1'b0});
        for (int k = 0; k < 4; k++) begin
            expect_eq($sformatf("R11 delayed match at cycle %0d", k), match, (k == 3) ? 1 : 0);
            if (k < 3) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        dnf = 4'd0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master();
        t_master_no_match();
        t_arb();
        t_seven();
        t_gcall();
        t_smb();
        t_ten();
        t_filter();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule